// File: doc/BRIEF.md
# Two-Real-Spectrum Separation Unit

One complex transform can carry the spectra of two real signals at once. This unit recovers both spectra from such a packed transform. Samples arrive one complex word per valid cycle and are taken two at a time: an even-indexed sample, then its odd-indexed neighbour. From each pair the unit forms two half-scaled complex results. These are built from cross-wise sums and differences of the real and imaginary parts. The first result belongs to one signal and the second to the other.

The two results of a pair leave on consecutive cycles, each marked by the output valid strobe, in frame order and with no reordering. A frame of N input points therefore gives N output points. Input valid may drop between samples or between frames. The pair phase moves only on a valid sample. A new pair may follow the previous one with no gap and no sample is lost.

Top module: `spectrum_splitter`

## Requirements
- R1: Input and output words are 2*CW bits wide (CW = 16 by default). The real part occupies bits [CW-1:0] and the imaginary part occupies bits [2*CW-1:CW]. Both parts are two's-complement signed.
- R2: After reset, the first valid sample is the even member x0 of a pair and the next valid sample is the odd member x1. The pair phase changes only on cycles where in_valid is high, and data present while in_valid is low has no effect on any output.
- R3: The first result of a pair has real part (re(x1)+re(x0))/2 and imaginary part (im(x0)-im(x1))/2.
- R4: The second result of a pair has real part (im(x1)+im(x0))/2 and imaginary part (re(x1)-re(x0))/2.
- R5: The halving rounds toward minus infinity: the sum or difference keeps its lowest bit only until the shift, which drops it (for example (-1+0)/2 gives -1).
- R6: The first result appears with out_valid high in the cycle after the clock edge that captures x1. The second result follows in the next cycle. out_valid is low in every other cycle.
- R7: Pairs arriving back-to-back lose no sample. Each valid input produces exactly one valid output, in input order.
- R8: A synchronous active-high reset clears out_valid and returns the pair phase to even. A half pair present before reset is discarded.
- R9: Sums and differences are formed at CW+1 bits, so full-scale operands give correct results with no wrap (for example (32767-(-32768))/2 gives 32767).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a valid input sample |
| in_word | input | 2*CW | Packed complex input, imaginary high, real low |
| out_valid | output | 1 | Marks a valid output result |
| out_word | output | 2*CW | Packed complex result, imaginary high, real low |

## Verification
The clock edge that captures the odd sample sets a timing reference. The first result is due in the cycle just after that edge and the second result in the cycle after that. When the driver sends the odd sample, it stamps each expected result with the exact cycle number at which that result should appear. The monitor samples on the falling edge. For every word marked valid it compares both the value and the cycle number against the stamps, so a result that is early, late or missing is reported as well as one that has the wrong value.

// File: rtl/sep_pkg.sv
package sep_pkg;
    localparam int unsigned SEP_CW_DEFAULT = 16;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } pair_phase_e;

    // lane order inside the arithmetic stage
    localparam int unsigned LANES = 4;
endpackage

// File: rtl/sep_pair_capture.sv
module sep_pair_capture
    import sep_pkg::*;
#(
    parameter int unsigned CW = SEP_CW_DEFAULT,
    localparam int unsigned WW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [WW-1:0] in_word,
    output logic          pair_done,
    output logic [WW-1:0] even_word
);
    typedef struct packed {
        pair_phase_e   phase;
        logic [WW-1:0] held;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        pair_done = 1'b0;
        if (in_valid) begin
            if (st_q.phase == PH_EVEN) begin
                st_d.held  = in_word;
                st_d.phase = PH_ODD;
            end else begin
                pair_done  = 1'b1;
                st_d.phase = PH_EVEN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_EVEN;
            st_q.held  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign even_word = st_q.held;
endmodule

// File: rtl/sep_butterfly.sv
module sep_butterfly
    import sep_pkg::*;
#(
    parameter int unsigned CW = SEP_CW_DEFAULT,
    localparam int unsigned WW = 2 * CW
) (
    input  logic [WW-1:0] x0_word,
    input  logic [WW-1:0] x1_word,
    output logic [WW-1:0] first_word,
    output logic [WW-1:0] second_word
);
    logic signed [CW-1:0] re0, im0, re1, im1;
    assign re0 = x0_word[CW-1:0];
    assign im0 = x0_word[WW-1:CW];
    assign re1 = x1_word[CW-1:0];
    assign im1 = x1_word[WW-1:CW];

    // lane 0: first.re, lane 1: first.im, lane 2: second.re, lane 3: second.im
    logic signed [CW-1:0] op_p [LANES];
    logic signed [CW-1:0] op_q [LANES];
    logic        [CW-1:0] lane_res [LANES];
    localparam logic [LANES-1:0] LANE_SUB = 4'b1010;

    always_comb begin
        op_p[0] = re1; op_q[0] = re0;
        op_p[1] = im0; op_q[1] = im1;
        op_p[2] = im1; op_q[2] = im0;
        op_p[3] = re1; op_q[3] = re0;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [CW:0] wide;
        logic               unused_lsb;
        always_comb begin
            if (LANE_SUB[k])
                wide = {op_p[k][CW-1], op_p[k]} - {op_q[k][CW-1], op_q[k]};
            else
                wide = {op_p[k][CW-1], op_p[k]} + {op_q[k][CW-1], op_q[k]};
        end
        assign lane_res[k] = wide[CW:1];
        assign unused_lsb  = wide[0];
    end

    assign first_word  = {lane_res[1], lane_res[0]};
    assign second_word = {lane_res[3], lane_res[2]};
endmodule

// File: rtl/sep_out_seq.sv
module sep_out_seq
    import sep_pkg::*;
#(
    parameter int unsigned CW = SEP_CW_DEFAULT,
    localparam int unsigned WW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pair_done,
    input  logic [WW-1:0] first_word,
    input  logic [WW-1:0] second_word,
    output logic          out_valid,
    output logic [WW-1:0] out_word
);
    typedef struct packed {
        logic [WW-1:0] word;
        logic          vld;
        logic [WW-1:0] pend;
        logic          pend_vld;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (pair_done) begin
            st_d.word     = first_word;
            st_d.vld      = 1'b1;
            st_d.pend     = second_word;
            st_d.pend_vld = 1'b1;
        end else if (st_q.pend_vld) begin
            st_d.word     = st_q.pend;
            st_d.vld      = 1'b1;
            st_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.word     <= '0;
            st_q.vld      <= 1'b0;
            st_q.pend     <= '0;
            st_q.pend_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;
endmodule

// File: rtl/spectrum_splitter.sv
module spectrum_splitter
    import sep_pkg::*;
#(
    parameter int unsigned CW = SEP_CW_DEFAULT,
    localparam int unsigned WW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [WW-1:0] in_word,
    output logic          out_valid,
    output logic [WW-1:0] out_word
);
    logic          pair_done;
    logic [WW-1:0] even_word;
    logic [WW-1:0] first_word, second_word;

    sep_pair_capture #(.CW(CW)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .pair_done (pair_done),
        .even_word (even_word)
    );

    sep_butterfly #(.CW(CW)) bfly_i (
        .x0_word     (even_word),
        .x1_word     (in_word),
        .first_word  (first_word),
        .second_word (second_word)
    );

    sep_out_seq #(.CW(CW)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .pair_done   (pair_done),
        .first_word  (first_word),
        .second_word (second_word),
        .out_valid   (out_valid),
        .out_word    (out_word)
    );
endmodule

// File: rtl/split_checker.sv
module split_checker (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid
);
    int unsigned in_cnt, out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= 0;
            out_cnt <= 0;
        end else begin
            in_cnt  <= in_cnt + (in_valid ? 1 : 0);
            out_cnt <= out_cnt + (out_valid ? 1 : 0);
        end
    end

    // R6
    first_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid));

    // R2
    valid_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) || $past(in_valid, 2)));

    // R8
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R7
    no_extra_output_chk: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= in_cnt);

    // R7
    no_lost_input_chk: assert property (@(posedge clk) disable iff (rst)
        (in_cnt - out_cnt) <= 2);
endmodule

bind spectrum_splitter split_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/spectrum_splitter_tb_top.sv
module spectrum_splitter_tb_top;
    localparam int CW = 16;
    localparam int WW = 2 * CW;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [WW-1:0] in_word = '0;
    logic          out_valid;
    logic [WW-1:0] out_word;

    spectrum_splitter #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_word(out_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [WW-1:0] word;
        int            due;
        string         tag;
    } exp_item_t;

    exp_item_t sb[$];
    int checks = 0, errors = 0;
    int cyc = 0;
    int n_in = 0, n_out = 0;
    bit phase_odd = 0;
    logic [WW-1:0] held0;
    logic [31:0] lcg = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [CW-1:0] half_of(int a, int b);
        int s;
        s = (a + b) >>> 1;
        return s[CW-1:0];
    endfunction

    function automatic int sre(logic [WW-1:0] w);
        return int'($signed(w[CW-1:0]));
    endfunction

    function automatic int sim(logic [WW-1:0] w);
        return int'($signed(w[WW-1:CW]));
    endfunction

    task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one valid sample, then idle cycles with junk data
    task automatic send(int re, int im, int gap, string tag);
        logic [WW-1:0] w;
        w = {im[CW-1:0], re[CW-1:0]};
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        n_in++;
        if (!phase_odd) begin
            held0 = w;
            phase_odd = 1;
        end else begin
            exp_item_t a, b;
            a.word = {half_of(sim(held0), -sim(w)), half_of(sre(w), sre(held0))};
            a.due  = cyc + 1;
            a.tag  = {"R3 ", tag};
            b.word = {half_of(sre(w), -sre(held0)), half_of(sim(w), sim(held0))};
            b.due  = cyc + 2;
            b.tag  = {"R4 ", tag};
            sb.push_back(a);
            sb.push_back(b);
            phase_odd = 0;
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = ~w ^ 32'h5a5a_a5a5;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = $urandom;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                n_out++;
                if (sb.size() == 0) begin
                    check(0, "R7 unexpected output", out_word, '0);
                end else begin
                    exp_item_t e;
                    e = sb.pop_front();
                    check(out_word == e.word, {e.tag, " value"}, out_word, e.word);
                    check(cyc == e.due, "R6 timing", WW'(cyc), WW'(e.due));
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 valid low in reset", WW'(out_valid), '0);
        rst = 1'b0;
        idle(2);

        // basic pair with explicit packing check
        send(100, 20, 0, "basic");
        send(30, -50, 0, "basic");
        @(negedge clk);
        in_valid = 1'b0;
        check(out_word == {16'sd35, 16'sd65}, "R1 packing", out_word, {16'sd35, 16'sd65});
        idle(3);

        // gaps with junk while invalid
        send(-700, 1234, 3, "R2 gaps");
        send(5000, -321, 4, "R2 gaps");
        send(7, 9, 1, "R2 gaps");
        send(-8, 3, 2, "R2 gaps");
        idle(4);

        // floor halving of odd sums
        send(-1, 0, 0, "R5 floor");
        send(0, -2, 0, "R5 floor");
        send(3, -3, 0, "R5 floor");
        send(-6, 4, 0, "R5 floor");
        idle(4);

        // full-scale operands
        send(32767, -32768, 0, "R9 extreme");
        send(32767, -32768, 0, "R9 extreme");
        send(-32768, 32767, 0, "R9 extreme");
        send(32767, -32768, 0, "R9 extreme");
        send(-32768, -32768, 0, "R9 extreme");
        send(-32768, -32768, 0, "R9 extreme");
        idle(4);

        // three back-to-back frames of eight points
        for (int f = 0; f < 3; f++) begin
            for (int p = 0; p < 8; p++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                send(int'($signed(lcg[31:16])), int'($signed(lcg[15:0])), 0, "R7 stream");
            end
        end
        idle(4);

        // reset in the middle of a pair
        send(999, -999, 0, "R8 drop");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        phase_odd = 0;
        n_in--;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 valid cleared", WW'(out_valid), '0);
        rst = 1'b0;
        send(40, 60, 0, "R8 after reset");
        send(-20, 10, 0, "R8 after reset");
        idle(5);

        check(sb.size() == 0, "R7 queue drained", WW'(sb.size()), '0);
        check(n_out == n_in, "R7 output count", WW'(n_out), WW'(n_in));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule